// File: doc/BRIEF.md
# Hashed Indirect Branch Target Predictor

This block predicts where an indirect branch will go. It is a set-associative target cache. Each way stores a tag, a target address and a valid bit. The set index is a hash built from three things: the branch address, the thread's global direction history, and the addresses reached by the last few indirect branches. Enable parameters switch the history term and the path term on or off. The caller supplies the path targets as a flat vector with slot 0 holding the most recent one. The block does not store path history.

The block also owns the global history register for a single thread. Each resolved or predicted direction shifts one bit into it. A lookup returns the history value it was indexed with as a checkpoint. The caller keeps that checkpoint and hands it back in two places. One is an update, whose index must be formed from that same history. The other is a recovery request, which either rebuilds the history after a wrong direction or restores it exactly when a prediction is discarded.

Top module: `ind_target_pred`

## Requirements
- R1: After synchronous reset the history reads zero and every way is invalid, so every lookup misses.
- R2: A lookup presented at a clock edge drives `lk_hit` and `lk_target` after that same edge, for one cycle. Hit means a valid way in the indexed set holds the lookup tag, and the target is that way's target.
- R3: With history hashing enabled, the set index is the low log2(SETS) bits of (PC >> SHIFT) XOR history. History bits above the index width do not change the set.
- R4: With path hashing enabled, each path slot p, where slot 0 is the most recent, is shifted right by SHIFT + p*(log2(SETS)/PATH_LEN) and XORed into the index. Bits that this shift drops have no effect.
- R5: The tag is bits [TAG_W-1:0] of (PC >> SHIFT). PCs that differ only above bit SHIFT+TAG_W and map to the same set alias to one entry.
- R6: An update whose tag already sits in a valid way of its set overwrites only that way's target. The other ways of the set stay unchanged.
- R7: An update that misses writes the lowest-numbered invalid way. When the set is full it writes exactly one way, picked pseudo-randomly, and the other ways keep their contents.
- R8: A direction outcome with no recovery in the same cycle makes the history {history[HIST_W-2:0], taken}.
- R9: A recovery with `rec_mode`=1 (mispredicted direction) makes the history {ckpt[HIST_W-2:0], rec_taken}.
- R10: A recovery with `rec_mode`=0 (discarded prediction) makes the history equal to `rec_ckpt`. A recovery takes priority over a direction outcome in the same cycle.
- R11: An update forms its index from `up_ckpt` and `up_path`, not from the current history.
- R12: A lookup and an update to the same set in the same cycle return the contents as they were before the update.
- R13: `lk_ckpt` returns the history value that was current in the cycle the lookup was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Branch address to predict |
| lk_path | input | PATH_LEN*PC_W | Recent path targets for the lookup, slot 0 in the low bits |
| lk_hit | output | 1 | Lookup hit, one cycle after request |
| lk_target | output | PC_W | Predicted target, valid with lk_hit |
| lk_ckpt | output | HIST_W | History used by the lookup, to be saved by the caller |
| up_valid | input | 1 | Update request |
| up_pc | input | PC_W | Resolved branch address |
| up_path | input | PATH_LEN*PC_W | Path targets that the branch's lookup saw |
| up_ckpt | input | HIST_W | History checkpoint that the branch's lookup returned |
| up_target | input | PC_W | Resolved target |
| dir_valid | input | 1 | Direction outcome strobe |
| dir_taken | input | 1 | Direction outcome bit |
| rec_valid | input | 1 | History recovery request |
| rec_mode | input | 1 | 1 = rebuild after wrong direction, 0 = restore exactly |
| rec_ckpt | input | HIST_W | Saved history for recovery |
| rec_taken | input | 1 | Actual direction used when rec_mode is 1 |
| hist_o | output | HIST_W | Current global history |

## Verification
A lookup's hit, target and checkpoint are due one clock edge after the request. The bench drives each request on a falling edge and samples all three just after the next rising edge. An update writes at the rising edge that ends its request cycle, so its effect is checked with a separate lookup issued afterwards. The only exception is the same-cycle case, which is checked against the old contents. History changes from direction or recovery strobes appear on `hist_o` one edge after the strobe and are sampled at that same point. The history sequence comes from a vector table, and the cache behaviour is covered by directed tests.

// File: rtl/itp_pkg.sv
package itp_pkg;
  typedef enum logic {
    REC_RESTORE = 1'b0,
    REC_REPLAY  = 1'b1
  } rec_mode_e;
endpackage

// File: rtl/itp_hash.sv
module itp_hash #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 8,
  parameter int HIST_W    = 8,
  parameter int PATH_LEN  = 2,
  parameter int SHIFT     = 2,
  parameter bit HASH_HIST = 1'b1,
  parameter bit HASH_PATH = 1'b1
) (
  input  logic [PC_W-1:0]          pc,
  input  logic [HIST_W-1:0]        hist,
  input  logic [PATH_LEN*PC_W-1:0] path,
  output logic [IDX_W-1:0]         idx,
  output logic [TAG_W-1:0]         tag
);
  localparam int STEP = IDX_W / PATH_LEN;

  logic [PC_W-1:0] pc_sh;
  logic [PC_W-1:0] mix;

  assign pc_sh = pc >> SHIFT;
  assign tag   = pc_sh[TAG_W-1:0];

  always_comb begin
    mix = pc_sh;
    if (HASH_HIST) mix = mix ^ PC_W'(hist);
    if (HASH_PATH) begin
      for (int p = 0; p < PATH_LEN; p++) begin
        mix = mix ^ (path[p*PC_W +: PC_W] >> (SHIFT + p*STEP));
      end
    end
    idx = mix[IDX_W-1:0];
  end
endmodule

// File: rtl/itp_history.sv
module itp_history
  import itp_pkg::*;
#(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_valid,
  input  logic              dir_taken,
  input  logic              rec_valid,
  input  logic              rec_mode,
  input  logic [HIST_W-1:0] rec_ckpt,
  input  logic              rec_taken,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (rec_valid) begin
      if (rec_mode_e'(rec_mode) == REC_REPLAY) hist <= {rec_ckpt[HIST_W-2:0], rec_taken};
      else                                     hist <= rec_ckpt;
    end else if (dir_valid) begin
      hist <= {hist[HIST_W-2:0], dir_taken};
    end
  end
endmodule

// File: rtl/itp_lfsr.sv
module itp_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst) state <= W'(1);
    else     state <= state[0] ? ((state >> 1) ^ W'(TAPS)) : (state >> 1);
  end
endmodule

// File: rtl/ind_target_pred.sv
module ind_target_pred #(
  parameter int PC_W      = 32,
  parameter int SETS      = 16,
  parameter int WAYS      = 2,
  parameter int TAG_W     = 8,
  parameter int HIST_W    = 8,
  parameter int PATH_LEN  = 2,
  parameter int SHIFT     = 2,
  parameter bit HASH_HIST = 1'b1,
  parameter bit HASH_PATH = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lk_valid,
  input  logic [PC_W-1:0]          lk_pc,
  input  logic [PATH_LEN*PC_W-1:0] lk_path,
  output logic                     lk_hit,
  output logic [PC_W-1:0]          lk_target,
  output logic [HIST_W-1:0]        lk_ckpt,
  input  logic                     up_valid,
  input  logic [PC_W-1:0]          up_pc,
  input  logic [PATH_LEN*PC_W-1:0] up_path,
  input  logic [HIST_W-1:0]        up_ckpt,
  input  logic [PC_W-1:0]          up_target,
  input  logic                     dir_valid,
  input  logic                     dir_taken,
  input  logic                     rec_valid,
  input  logic                     rec_mode,
  input  logic [HIST_W-1:0]        rec_ckpt,
  input  logic                     rec_taken,
  output logic [HIST_W-1:0]        hist_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int RND_W = 16;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag, lk_tag_q;
  logic             lk_v_q;
  logic [RND_W-1:0] rnd;

  logic [TAG_W-1:0] rd_tag [WAYS];
  logic [PC_W-1:0]  rd_tgt [WAYS];
  logic             rd_vld [WAYS];
  logic [TAG_W-1:0] up_row_tag [WAYS];
  logic             up_row_vld [WAYS];
  logic [WAYS-1:0]  up_match;
  logic [WAYS-1:0]  way_we;
  logic             free_found;
  logic [WAY_W-1:0] free_way, rnd_way, victim;

  itp_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W),
             .PATH_LEN(PATH_LEN), .SHIFT(SHIFT), .HASH_HIST(HASH_HIST),
             .HASH_PATH(HASH_PATH)) u_lk_hash (
    .pc(lk_pc), .hist(hist_o), .path(lk_path), .idx(lk_idx), .tag(lk_tag));

  itp_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W),
             .PATH_LEN(PATH_LEN), .SHIFT(SHIFT), .HASH_HIST(HASH_HIST),
             .HASH_PATH(HASH_PATH)) u_up_hash (
    .pc(up_pc), .hist(up_ckpt), .path(up_path), .idx(up_idx), .tag(up_tag));

  itp_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .dir_valid(dir_valid), .dir_taken(dir_taken),
    .rec_valid(rec_valid), .rec_mode(rec_mode), .rec_ckpt(rec_ckpt),
    .rec_taken(rec_taken), .hist(hist_o));

  itp_lfsr #(.W(RND_W)) u_lfsr (.clk(clk), .rst(rst), .state(rnd));

  // Per-way storage: tag and target arrays without reset, valid bits with reset.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [PC_W-1:0]  tgt_mem [SETS];
    logic [SETS-1:0]  vld;
    logic [TAG_W-1:0] rd_tag_q;
    logic [PC_W-1:0]  rd_tgt_q;
    logic             rd_vld_q;

    always_ff @(posedge clk) begin
      if (way_we[w]) begin
        tag_mem[up_idx] <= up_tag;
        tgt_mem[up_idx] <= up_target;
      end
      if (lk_valid) begin
        rd_tag_q <= tag_mem[lk_idx];
        rd_tgt_q <= tgt_mem[lk_idx];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld      <= '0;
        rd_vld_q <= 1'b0;
      end else begin
        if (way_we[w]) vld[up_idx] <= 1'b1;
        if (lk_valid)  rd_vld_q    <= vld[lk_idx];
      end
    end

    assign rd_tag[w]     = rd_tag_q;
    assign rd_tgt[w]     = rd_tgt_q;
    assign rd_vld[w]     = rd_vld_q;
    assign up_row_tag[w] = tag_mem[up_idx];
    assign up_row_vld[w] = vld[up_idx];
    assign up_match[w]   = up_row_vld[w] && (up_row_tag[w] == up_tag);
  end

  // Victim choice: lowest invalid way, else pseudo-random way.
  assign rnd_way = WAY_W'(rnd % RND_W'(WAYS));

  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!up_row_vld[w]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
    victim = free_found ? free_way : rnd_way;
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (|up_match) way_we[w] = up_valid && up_match[w];
      else           way_we[w] = up_valid && (victim == WAY_W'(w));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_v_q   <= 1'b0;
      lk_tag_q <= '0;
      lk_ckpt  <= '0;
    end else begin
      lk_v_q <= lk_valid;
      if (lk_valid) begin
        lk_tag_q <= lk_tag;
        lk_ckpt  <= hist_o;
      end
    end
  end

  always_comb begin
    lk_hit    = 1'b0;
    lk_target = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_v_q && rd_vld[w] && (rd_tag[w] == lk_tag_q)) begin
        lk_hit    = 1'b1;
        lk_target = rd_tgt[w];
      end
    end
  end
endmodule

// File: rtl/itp_checker.sv
module itp_checker #(
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              lk_hit,
  input logic [HIST_W-1:0] lk_ckpt,
  input logic              dir_valid,
  input logic              dir_taken,
  input logic              rec_valid,
  input logic              rec_mode,
  input logic [HIST_W-1:0] rec_ckpt,
  input logic              rec_taken,
  input logic [HIST_W-1:0] hist_o
);
  a_r1_reset_hist: assert property (@(posedge clk)
    $past(rst) |-> hist_o == '0);

  a_r2_hit_needs_req: assert property (@(posedge clk) disable iff (rst)
    !$past(lk_valid) |-> !lk_hit);

  a_r8_dir_shift: assert property (@(posedge clk) disable iff (rst)
    (dir_valid && !rec_valid) |=> hist_o == {$past(hist_o[HIST_W-2:0]), $past(dir_taken)});

  a_r9_replay: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_mode) |=> hist_o == {$past(rec_ckpt[HIST_W-2:0]), $past(rec_taken)});

  a_r10_restore: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_mode) |=> hist_o == $past(rec_ckpt));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!rec_valid && !dir_valid) |=> $stable(hist_o));

  a_r13_ckpt: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_ckpt == $past(hist_o));
endmodule

bind ind_target_pred itp_checker #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_ckpt(lk_ckpt),
  .dir_valid(dir_valid), .dir_taken(dir_taken), .rec_valid(rec_valid),
  .rec_mode(rec_mode), .rec_ckpt(rec_ckpt), .rec_taken(rec_taken), .hist_o(hist_o));

// File: tb/ind_target_pred_tb.sv
module ind_target_pred_tb;
  localparam int PC_W = 32;
  localparam int HW   = 8;
  localparam int PL   = 2;

  logic clk = 1'b0;
  logic rst;
  logic lk_valid, up_valid, dir_valid, dir_taken, rec_valid, rec_mode, rec_taken;
  logic [PC_W-1:0] lk_pc, up_pc, up_target, lk_target;
  logic [PL*PC_W-1:0] lk_path, up_path;
  logic [HW-1:0] up_ckpt, rec_ckpt, lk_ckpt, hist_o;
  logic lk_hit;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ind_target_pred u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_path(lk_path),
    .lk_hit(lk_hit), .lk_target(lk_target), .lk_ckpt(lk_ckpt),
    .up_valid(up_valid), .up_pc(up_pc), .up_path(up_path), .up_ckpt(up_ckpt),
    .up_target(up_target), .dir_valid(dir_valid), .dir_taken(dir_taken),
    .rec_valid(rec_valid), .rec_mode(rec_mode), .rec_ckpt(rec_ckpt),
    .rec_taken(rec_taken), .hist_o(hist_o));

  // History vectors: {kind[1:0], taken, ckpt[7:0], expected[7:0]}
  // kind 0 = direction, 1 = restore, 2 = replay after wrong direction
  localparam int NV = 8;
  localparam logic [18:0] HVEC [NV] = '{
    {2'd0, 1'b1, 8'h00, 8'h01},
    {2'd0, 1'b1, 8'h00, 8'h03},
    {2'd0, 1'b0, 8'h00, 8'h06},
    {2'd1, 1'b0, 8'hA5, 8'hA5},
    {2'd0, 1'b1, 8'h00, 8'h4B},
    {2'd2, 1'b0, 8'h80, 8'h00},
    {2'd2, 1'b1, 8'h7F, 8'hFF},
    {2'd0, 1'b0, 8'h00, 8'hFE}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    lk_valid = 0; up_valid = 0; dir_valid = 0; rec_valid = 0;
    dir_taken = 0; rec_mode = 0; rec_taken = 0;
  endtask

  task automatic set_hist(input logic [HW-1:0] h);
    @(negedge clk);
    rec_valid = 1; rec_mode = 0; rec_ckpt = h;
    @(negedge clk);
    rec_valid = 0;
  endtask

  task automatic do_update(input logic [PC_W-1:0] pc, input logic [PL*PC_W-1:0] path,
                           input logic [HW-1:0] ck, input logic [PC_W-1:0] tgt);
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_path = path; up_ckpt = ck; up_target = tgt;
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic do_lookup(input logic [PC_W-1:0] pc, input logic [PL*PC_W-1:0] path,
                           output logic hit, output logic [PC_W-1:0] tgt);
    @(negedge clk);
    lk_valid = 1; lk_pc = pc; lk_path = path;
    @(posedge clk);
    #1;
    lk_valid = 0;
    hit = lk_hit; tgt = lk_target;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic h;
    logic [PC_W-1:0] t;
    logic ha, hb;
    logic [PL*PC_W-1:0] pz, pp;
    pz = '0;
    quiet();
    lk_pc = '0; lk_path = '0; up_pc = '0; up_path = '0; up_ckpt = '0; up_target = '0; rec_ckpt = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    check("R1 hist", hist_o, 0);
    do_lookup(32'h100, pz, h, t);
    check("R1 miss", h, 0);

    // R8 R9 R10: history vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      case (HVEC[i][18:17])
        2'd0: begin dir_valid = 1; dir_taken = HVEC[i][16]; end
        2'd1: begin rec_valid = 1; rec_mode = 0; rec_ckpt = HVEC[i][15:8]; end
        default: begin rec_valid = 1; rec_mode = 1; rec_ckpt = HVEC[i][15:8]; rec_taken = HVEC[i][16]; end
      endcase
      @(posedge clk); #1;
      quiet();
      check("R8/R9/R10 hist vector", hist_o, HVEC[i][7:0]);
    end

    // R10: recovery beats direction in the same cycle
    @(negedge clk);
    rec_valid = 1; rec_mode = 0; rec_ckpt = 8'h3C; dir_valid = 1; dir_taken = 1;
    @(posedge clk); #1; quiet();
    check("R10 priority", hist_o, 8'h3C);

    set_hist(8'h00);
    // R2 R5: PC 0x40 -> index 0, tag 0x10
    do_update(32'h40, pz, 8'h00, 32'h1111_0000);
    do_lookup(32'h40, pz, h, t);
    check("R2 hit", h, 1);
    check("R2 target", t, 32'h1111_0000);

    // R3: history low bits steer the set, upper bits do not
    set_hist(8'h01);
    do_lookup(32'h40, pz, h, t);
    check("R3 history moves set", h, 0);
    set_hist(8'h10);
    do_lookup(32'h40, pz, h, t);
    check("R3 high history bits ignored", h, 1);

    // R11: update indexed by its checkpoint (0x01), not current history (0x10)
    do_update(32'h40, pz, 8'h01, 32'h2222_0000);
    do_lookup(32'h40, pz, h, t);
    check("R11 current-history set untouched", t, 32'h1111_0000);
    set_hist(8'h01);
    do_lookup(32'h40, pz, h, t);
    check("R11 checkpoint set written", t, 32'h2222_0000);
    set_hist(8'h00);

    // R5: aliasing above tag bits, miss on tag bit difference
    do_lookup(32'h1040, pz, h, t);
    check("R5 alias hit", t, 32'h1111_0000);
    do_lookup(32'h140, pz, h, t);
    check("R5 tag differs", h, 0);

    // R6: fill set 0 with B, rewrite A, B must survive
    do_update(32'h140, pz, 8'h00, 32'h3333_0000);
    do_update(32'h40, pz, 8'h00, 32'h4444_0000);
    do_lookup(32'h40, pz, h, t);
    check("R6 target rewritten", t, 32'h4444_0000);
    do_lookup(32'h140, pz, h, t);
    check("R6 other way kept", t, 32'h3333_0000);

    // R7: full set, new tag replaces exactly one way
    do_update(32'h240, pz, 8'h00, 32'h5555_0000);
    do_lookup(32'h240, pz, h, t);
    check("R7 new entry", t, 32'h5555_0000);
    do_lookup(32'h40, pz, ha, t);
    do_lookup(32'h140, pz, hb, t);
    check("R7 one survivor", 32'(ha) + 32'(hb), 1);

    // R4: PC 0x84 (idx 1, tag 0x21), slot0 0x8 -> 2, slot1 0x40 >> 4 -> 4, set 7
    pp = {32'h40, 32'h08};
    do_update(32'h84, pp, 8'h00, 32'h6666_0000);
    do_lookup(32'h84, pp, h, t);
    check("R4 path hit", t, 32'h6666_0000);
    do_lookup(32'h84, pz, h, t);
    check("R4 path changes set", h, 0);
    do_lookup(32'h84, {32'h44, 32'h08}, h, t);
    check("R4 dropped slot1 bit", h, 1);
    do_lookup(32'h84, {32'h50, 32'h08}, h, t);
    check("R4 slot1 kept bit", h, 0);
    do_lookup(32'h84, {32'h40, 32'h0C}, h, t);
    check("R4 slot0 kept bit", h, 0);

    // R12: same-cycle update and lookup to set 3
    @(negedge clk);
    up_valid = 1; up_pc = 32'h0C; up_path = pz; up_ckpt = 0; up_target = 32'h7777_0000;
    lk_valid = 1; lk_pc = 32'h0C; lk_path = pz;
    @(posedge clk); #1;
    quiet();
    check("R12 old contents", lk_hit, 0);
    do_lookup(32'h0C, pz, h, t);
    check("R12 later hit", t, 32'h7777_0000);

    // R13: checkpoint is history before a same-cycle direction
    set_hist(8'h5A);
    @(negedge clk);
    lk_valid = 1; lk_pc = 32'h0C; lk_path = pz; dir_valid = 1; dir_taken = 1;
    @(posedge clk); #1;
    quiet();
    check("R13 checkpoint", lk_ckpt, 8'h5A);
    check("R8 shift with lookup", hist_o, 8'hB5);

    // R1: reset mid-run clears entries and history
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 hist after reset", hist_o, 0);
    do_lookup(32'h40, pz, h, t);
    check("R1 entries cleared", h, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule